// File: doc/BRIEF.md
# Synchronous Serial Slave Receiver

This block accepts serial words from an external master. The master drives both the shift clock and a single data line. Both lines are brought into the system clock domain through two-flop synchronizers. A data bit is taken on every falling edge of the synchronized shift clock, least significant bit first. When the last bit of a word arrives, the word leaves the shift register and goes into a two-entry holding queue. The host reads that queue through a small register bus.

The host sets up the port through a control register. Reception only runs when all of these hold:
- the port is switched on;
- synchronous operation is chosen;
- the clock-source bit selects the external clock;
- the continuous-receive bit is set.

Words may be eight or nine bits long. In nine-bit mode the extra bit of the oldest unread word appears in the status register. The host reads it before it reads the data register, because reading data pops the word. A completed word can raise an interrupt request, and that request also serves as a wake request. Nothing in the receive path waits on the host, so a word still arrives while the host is idle.

If a third word completes while two words are still unread, that word is dropped and an overrun flag is set. Reception then stops until the host clears the continuous-receive bit.

Top module: `ssrx_slave`

## Requirements
- R1: Words are captured only when CTRL bit0 (port on), CTRL bit1 (synchronous) and CTRL bit4 (continuous receive) are 1 and CTRL bit2 (internal clock source) is 0. In any other setting the shift clock has no effect and the bit counter stays at its start state.
- R2: CTRL bit5 (single-word request) has no effect on reception, whether it is 0 or 1.
- R3: Data is sampled on each falling edge of the shift clock, least significant bit first. After 8 edges (or 9 edges in nine-bit mode) the word enters the holding queue and STATUS bit2 (receive complete) reads 1.
- R4: Outputs irq and wake are 1 exactly while CTRL bit6 (receive interrupt enable) is 1 and at least one word is unread.
- R5: When CTRL bit3 is 1, words are nine bits long. The ninth received bit of the oldest unread word reads in STATUS bit0. In eight-bit mode STATUS bit0 reads 0.
- R6: Clearing CTRL bit4 clears the overrun flag, STATUS bit1.
- R7: The queue holds two words in arrival order. A bus read of DATA (address 2) returns the oldest word in its low 8 bits and removes it. STATUS bit2 clears when no word is left.
- R8: When a word completes while two words are unread and no DATA read happens in that cycle, STATUS bit1 is set and the new word is discarded. Later words are ignored until CTRL bit4 is cleared.
- R9: After reset, CTRL and STATUS read 0, irq and wake are 0, and the bit counter is at its start state.
- R10: A word that completes in the same cycle as a DATA read of a full queue is accepted without overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sclk_in | input | 1 | Shift clock from the external master; idles high |
| sdat_in | input | 1 | Serial data from the external master |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; a read of DATA removes a word |
| bus_addr | input | 2 | Register address: 0 CTRL, 1 STATUS, 2 DATA |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| irq | output | 1 | Receive interrupt request |
| wake | output | 1 | Wake request; follows irq |

## Verification
The case that needs care is a word completing in the same cycle that the host reads DATA from a full queue. The push and the pop fall in the same cycle, and the design must accept the word instead of flagging an overrun. The bench knows the synchronizer latency, so it places a DATA read in the exact system-clock cycle in which the final falling edge is acted on. It then checks three things: the read returned the oldest word, the overrun flag is still 0, and the next two reads return the remaining words in order. Random words of random length, with the single-word request bit toggled at random, are also compared against bench-computed data and ninth-bit values.

// File: rtl/ssrx_slave.sv
module ssrx_slave #(
  parameter int DW = 8,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk_in,
  input  logic          sdat_in,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq,
  output logic          wake
);
  localparam int SW = DW + 1;
  localparam int CW = $clog2(SW + 1);
  localparam logic [CW-1:0] LAST_LONG  = CW'(SW - 1);
  localparam logic [CW-1:0] LAST_SHORT = CW'(SW - 2);
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_STAT = AW'(1);
  localparam logic [AW-1:0] A_DATA = AW'(2);

  logic port_on, sync_md, int_clk, long_md, cont_rx, one_shot, rx_ie;
  logic ovr;
  logic s1, s2, s3, d1, d2;
  logic [SW-1:0] shreg, nsh, word, q0, q1;
  logic [CW-1:0] bitcnt;
  logic [1:0] cnt;
  logic active, fall, last, done_w, pop, push, ovr_set;

  assign active  = port_on & sync_md & ~int_clk & cont_rx & ~ovr;
  assign fall    = s3 & ~s2;
  assign nsh     = {d2, shreg[SW-1:1]};
  assign last    = bitcnt == (long_md ? LAST_LONG : LAST_SHORT);
  assign done_w  = active & fall & last;
  assign word    = long_md ? nsh : {1'b0, nsh[SW-1:1]};
  assign pop     = bus_rd & (bus_addr == A_DATA) & (cnt != 2'd0);
  assign push    = done_w & ((cnt != 2'd2) | pop);
  assign ovr_set = done_w & (cnt == 2'd2) & ~pop;
  assign irq     = rx_ie & (cnt != 2'd0);
  assign wake    = irq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1; s2 <= 1'b1; s3 <= 1'b1;
      d1 <= 1'b0; d2 <= 1'b0;
    end else begin
      s1 <= sclk_in; s2 <= s1; s3 <= s2;
      d1 <= sdat_in; d2 <= d1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      port_on <= 1'b0; sync_md <= 1'b0; int_clk <= 1'b0; long_md <= 1'b0;
      cont_rx <= 1'b0; one_shot <= 1'b0; rx_ie <= 1'b0;
    end else if (bus_wr && bus_addr == A_CTRL) begin
      port_on  <= bus_wdata[0];
      sync_md  <= bus_wdata[1];
      int_clk  <= bus_wdata[2];
      long_md  <= bus_wdata[3];
      cont_rx  <= bus_wdata[4];
      one_shot <= bus_wdata[5];
      rx_ie    <= bus_wdata[6];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitcnt <= '0;
      shreg  <= '0;
    end else if (!active) begin
      bitcnt <= '0;
    end else if (fall) begin
      shreg  <= nsh;
      bitcnt <= last ? '0 : bitcnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovr <= 1'b0;
    else if (!cont_rx) ovr <= 1'b0;
    else if (ovr_set) ovr <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q0 <= '0; q1 <= '0; cnt <= 2'd0;
    end else if (push && pop) begin
      if (cnt == 2'd1) q0 <= word;
      else begin q0 <= q1; q1 <= word; end
    end else if (pop) begin
      q0  <= q1;
      cnt <= cnt - 2'd1;
    end else if (push) begin
      if (cnt == 2'd0) q0 <= word;
      else q1 <= word;
      cnt <= cnt + 2'd1;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL: bus_rdata = DW'({rx_ie, one_shot, cont_rx, long_md, int_clk, sync_md, port_on});
      A_STAT: bus_rdata = DW'({cnt != 2'd0, ovr, q0[SW-1]});
      A_DATA: bus_rdata = q0[DW-1:0];
      default: bus_rdata = '0;
    endcase
  end

  p_cnt_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= 2'd2);
  p_idle_counter_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> bitcnt == '0);
  p_push_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> cnt != 2'd0);
  p_last_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && cnt == 2'd1) |=> cnt == 2'd0);
  p_discard_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_set |=> (cnt == 2'd2) && ovr && $stable(q0) && $stable(q1));
  p_ovr_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cont_rx |=> !ovr);
  p_ovr_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && cont_rx && !(bus_wr && bus_addr == A_CTRL)) |=> ovr);
  p_same_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done_w && pop && cnt == 2'd2) |=> !ovr && cnt == 2'd2);
  p_irq_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(push) || $past(bus_wr));
endmodule

// File: tb/tb_ssrx_slave.sv
module tb_ssrx_slave;
  localparam int HALF = 6;
  localparam logic [7:0] EN = 8'h01, SYN = 8'h02, MST = 8'h04, NINE = 8'h08,
                         CONT = 8'h10, ONE = 8'h20, IE = 8'h40;
  localparam logic [7:0] BASE = EN | SYN | CONT;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk_in = 1'b1, sdat_in = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic irq, wake;
  int checks = 0, errors = 0;
  logic [7:0] v;

  ssrx_slave dut (.clk(clk), .rst_n(rst_n), .sclk_in(sclk_in), .sdat_in(sdat_in),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq), .wake(wake));

  always #5 clk = ~clk;

  function automatic logic [7:0] exp_data(logic [8:0] w);
    return w[7:0];
  endfunction
  function automatic logic exp_ninth(logic [8:0] w, logic nine);
    return nine ? w[8] : 1'b0;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr_ctrl(logic [7:0] val);
    @(negedge clk); bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = val;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic peek(logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic pop(output logic [7:0] d);
    @(negedge clk); bus_addr = 2'd2; bus_rd = 1'b1; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic send(logic [8:0] w, int n, bit rd_last, output logic [7:0] rd_val);
    rd_val = 8'h00;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sdat_in = w[i]; sclk_in = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk_in = 1'b0;
      if (rd_last && i == n - 1) begin
        @(negedge clk); @(negedge clk);
        bus_addr = 2'd2; bus_rd = 1'b1; #1 rd_val = bus_rdata;
        @(negedge clk); bus_rd = 1'b0;
        repeat (HALF - 3) @(negedge clk);
      end else begin
        repeat (HALF - 1) @(negedge clk);
      end
    end
    @(negedge clk); sclk_in = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d, t;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    peek(2'd0, d); chk("R9 ctrl", d, 8'h00);
    peek(2'd1, d); chk("R9 status", d, 8'h00);
    chk("R9 irq", {irq, wake}, 2'b00);

    wr_ctrl(EN | SYN | ONE);
    send(9'h05A, 8, 0, t);
    peek(2'd1, d); chk("R2 single bit alone", d[2], 1'b0);
    wr_ctrl(EN | CONT);
    send(9'h05A, 8, 0, t);
    peek(2'd1, d); chk("R1 no sync mode", d[2], 1'b0);
    wr_ctrl(EN | SYN | MST | CONT);
    send(9'h05A, 8, 0, t);
    peek(2'd1, d); chk("R1 internal clock", d[2], 1'b0);
    wr_ctrl(SYN | CONT);
    send(9'h05A, 8, 0, t);
    peek(2'd1, d); chk("R1 port off", d[2], 1'b0);

    wr_ctrl(BASE);
    send(9'h0A5, 8, 0, t);
    peek(2'd1, d); chk("R3 status after word", d, 8'h04);
    chk("R4 irq off when disabled", irq, 1'b0);
    pop(d); chk("R3 data", d, 8'hA5);
    peek(2'd1, d); chk("R7 empty after pop", d[2], 1'b0);

    wr_ctrl(BASE | IE);
    chk("R4 no irq when empty", irq, 1'b0);
    send(9'h03C, 8, 0, t);
    chk("R4 irq and wake", {irq, wake}, 2'b11);
    pop(d); chk("R4 data", d, 8'h3C);
    chk("R4 irq drops", irq, 1'b0);

    wr_ctrl(BASE | NINE);
    send(9'h1C3, 9, 0, t);
    peek(2'd1, d); chk("R5 ninth set", d[0], 1'b1);
    pop(d); chk("R5 data", d, 8'hC3);
    send(9'h0FF, 9, 0, t);
    peek(2'd1, d); chk("R5 ninth clear", d[0], 1'b0);
    pop(d); chk("R5 data2", d, 8'hFF);

    wr_ctrl(BASE);
    send(9'h011, 8, 0, t);
    send(9'h022, 8, 0, t);
    pop(d); chk("R7 first", d, 8'h11);
    peek(2'd1, d); chk("R7 still pending", d[2], 1'b1);
    pop(d); chk("R7 second", d, 8'h22);
    peek(2'd1, d); chk("R7 drained", d[2], 1'b0);

    send(9'h031, 8, 0, t);
    send(9'h032, 8, 0, t);
    send(9'h033, 8, 0, t);
    peek(2'd1, d); chk("R8 overrun", d[2:1], 2'b11);
    send(9'h034, 8, 0, t);
    pop(d); chk("R8 keep oldest", d, 8'h31);
    pop(d); chk("R8 keep second", d, 8'h32);
    peek(2'd1, d); chk("R8 third discarded", d, 8'h02);
    send(9'h035, 8, 0, t);
    peek(2'd1, d); chk("R8 blocked", d[2], 1'b0);
    wr_ctrl(EN | SYN);
    peek(2'd1, d); chk("R6 overrun cleared", d[1], 1'b0);
    wr_ctrl(BASE);
    send(9'h036, 8, 0, t);
    pop(d); chk("R8 resumes", d, 8'h36);

    send(9'h041, 8, 0, t);
    send(9'h042, 8, 0, t);
    send(9'h043, 8, 1, t);
    chk("R10 read returns oldest", t, 8'h41);
    peek(2'd1, d); chk("R10 no overrun", d[2:1], 2'b10);
    pop(d); chk("R10 second", d, 8'h42);
    pop(d); chk("R10 accepted", d, 8'h43);

    for (int k = 0; k < 20; k++) begin
      logic [8:0] w;
      logic nine, one;
      w = 9'($urandom); nine = 1'($urandom); one = 1'($urandom);
      wr_ctrl(BASE | (nine ? NINE : 8'h00) | (one ? ONE : 8'h00));
      send(w, nine ? 9 : 8, 0, t);
      peek(2'd1, d); chk("R5 random ninth", d[0], exp_ninth(w, nine));
      pop(d); chk("R2 R3 random data", d, exp_data(w));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule